// File: doc/BRIEF.md
# Sixteen-Bit Multi-Mode Timer with Input Capture

This block is a 16-bit counter that a four-bit mode field sets up as a free-running timer, a clear-on-match timer, a single-slope PWM generator or a dual-slope (up/down) PWM generator. The top of the count is fixed (full range, 8, 9 or 10 bits) or comes from compare register A or from the capture register. Three compare channels each drive one output pin. Each channel has a two-bit action field whose meaning depends on the mode family. A shared prescaler supplies the count tick. The tick source is the system clock divided by a fixed factor or a synchronised external clock pin, on either edge.

An input-capture unit synchronises a capture pin and can pass it through a majority-free run-length filter. On the selected edge it latches the current count. A plain 16-bit register port sets up the control word, count, compares, capture value, interrupt enables, flags and force strobes. Flags are set by events and cleared by writing a one. The interrupt request is raised when any enabled flag is set.

The counting engine is a two-state machine, `ST_UP` and `ST_DOWN`. In single-slope and free-running modes it stays in `ST_UP`. On a tick at the top it wraps to zero, and that wrap is the bottom event. In dual-slope modes, a tick at the top moves it from `ST_UP` to `ST_DOWN`. A tick at zero moves it from `ST_DOWN` back to `ST_UP`, and that transition is the bottom event. Writing the control word restarts the machine in `ST_UP`.

Top module: `mtimer16`

## Requirements
- R1: Mode 0 counts up by one per tick through 0xFFFF and then to 0. The tick that wraps 0xFFFF to 0 sets flag bit 0 (overflow).
- R2: The clear-on-match and single-slope modes count from 0 up to a top and return to 0 on the next tick, setting flag bit 0 on that tick. The tops are: mode 4 uses compare A, mode 12 uses the capture register, modes 5, 6 and 7 use 0x00FF, 0x01FF and 0x03FF, mode 14 uses the capture register and mode 15 uses compare A.
- R3: Modes 8 (top = capture register) and 9 (top = compare A) count up to the top, then down to 0, then up again. The tick taken at 0 while counting down sets flag bit 0.
- R4: The clock field selects the tick source: 0 stopped, 1 every clock, 2 one in 8, 3 one in 64, 4 one in 256, 5 one in 1024, 6 falling edge of `ext_clk_in`, 7 rising edge of `ext_clk_in`. Without a tick the count only changes by register write.
- R5: In modes 0, 4 and 12, a tick with the count equal to a channel's compare value applies its action: 0 none, 1 toggle, 2 drive 0, 3 drive 1. Every match in any mode sets that channel's flag (bit 1 + channel).
- R6: In modes 5, 6, 7, 14 and 15, action 2 drives the pin to 0 on a match and to 1 at the bottom event. Action 3 does the opposite. Actions 0 and 1 leave the pin unchanged. When both a match and the bottom event occur on the same tick, the bottom event wins.
- R7: In modes 8 and 9, action 2 drives the pin to 0 on a match while counting up and to 1 on a match while counting down. Action 3 does the opposite. Actions 0 and 1 leave the pin unchanged.
- R8: In mode 15, a write to compare A goes to a holding register. The active value, which is also the top, is loaded from it on the bottom event. Reading compare A returns the holding register.
- R9: The capture unit latches the count into the capture register and sets flag bit 4 on a rising edge (control bit 7 = 1) or a falling edge (bit 7 = 0) of `cap_in`. Capture is inhibited in modes 8, 12 and 14, where that register is the top.
- R10: With control bit 8 set, a level change on `cap_in` is accepted only after 4 consecutive synchronised samples of the new level. A 3-cycle pulse is therefore dropped and a 4-cycle pulse is kept. With bit 8 clear, a 2-cycle pulse is accepted.
- R11: Writing a one to force bit n (register 5) applies channel n's action at once in modes 0, 4 and 12, without setting its flag. In the PWM modes the force write has no effect on the pin.
- R12: Writing a one to a bit of the flag register (4) clears it, but a set event on the same cycle wins. `irq` is high exactly when a flag and its enable bit (register 3, same bit position) are both one.
- R13: The register map is: 0 control ([3:0] mode, [6:4] clock, [7] edge, [8] filter, [10:9] action A, [12:11] action B, [14:13] action C), 1 count, 2 capture, 3 enables, 4 flags, 5 force (reads 0), 6 to 8 compare A to C. A count write takes priority over a tick. After reset every register, pin and flag is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ext_clk_in | input | 1 | External count clock |
| cap_in | input | 1 | Input-capture pin |
| cmp_pin | output | 3 | Compare output pins, bit n = channel n |
| flags | output | 5 | Flag register: overflow, match A to C, capture |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the turn points of the counting machine: the `ST_UP` to `ST_DOWN` turn at the top, the bottom event in dual-slope modes, and the load of compare A from its holding register, which happens only on the bottom event. The stimulus selects the rising external clock as the tick source and gives one pulse per step on `ext_clk_in`. This steps the counter exactly one count at a time, so every turn, wrap and pin change is compared against a bench model after each tick. The modes, tops, compare values and actions are random. The filter boundary is driven directly with 3- and 4-cycle capture pulses while the counter is stopped.

// File: rtl/mtim_pkg.sv
`timescale 1ns/1ps
package mtim_pkg;

    typedef enum logic [1:0] {
        SHP_NORMAL,
        SHP_SINGLE,
        SHP_DUAL
    } shape_e;

    typedef enum logic [2:0] {
        TOP_FULL,
        TOP_CMPA,
        TOP_CAPT,
        TOP_BITS8,
        TOP_BITS9,
        TOP_BITS10
    } top_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_TOGGLE,
        ACT_CLEAR,
        ACT_SET
    } act_e;

    typedef struct packed {
        shape_e shape;
        top_e   top;
        logic   buffered;
        logic   cap_is_top;
    } mode_t;

    localparam int A_CTRL  = 0;
    localparam int A_COUNT = 1;
    localparam int A_CAPT  = 2;
    localparam int A_IEN   = 3;
    localparam int A_FLAGS = 4;
    localparam int A_FORCE = 5;
    localparam int A_CMP0  = 6;

    localparam int F_MODE = 0;
    localparam int F_CLK  = 4;
    localparam int F_EDGE = 7;
    localparam int F_FILT = 8;
    localparam int F_ACT  = 9;

    function automatic mode_t decode_mode(input logic [3:0] code);
        mode_t m;
        m = '{shape: SHP_NORMAL, top: TOP_FULL, buffered: 1'b0, cap_is_top: 1'b0};
        case (code)
            4'd4:  m.top = TOP_CMPA;
            4'd12: begin m.top = TOP_CAPT; m.cap_is_top = 1'b1; end
            4'd5:  begin m.shape = SHP_SINGLE; m.top = TOP_BITS8; end
            4'd6:  begin m.shape = SHP_SINGLE; m.top = TOP_BITS9; end
            4'd7:  begin m.shape = SHP_SINGLE; m.top = TOP_BITS10; end
            4'd8:  begin m.shape = SHP_DUAL; m.top = TOP_CAPT; m.cap_is_top = 1'b1; end
            4'd9:  begin m.shape = SHP_DUAL; m.top = TOP_CMPA; end
            4'd14: begin m.shape = SHP_SINGLE; m.top = TOP_CAPT; m.cap_is_top = 1'b1; end
            4'd15: begin m.shape = SHP_SINGLE; m.top = TOP_CMPA; m.buffered = 1'b1; end
            default: ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mtim_tick.sv
`timescale 1ns/1ps
module mtim_tick #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       ext_in,
    output logic       tick
);
    localparam int T8   = 3;
    localparam int T64  = 6;
    localparam int T256 = 8;
    localparam int T1K  = PRE_W;

    logic [PRE_W-1:0] pre_q;
    logic [2:0]       ext_q;
    logic             ext_rise;
    logic             ext_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ext_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            ext_q <= {ext_q[1:0], ext_in};
        end
    end

    always_comb begin
        ext_rise = ext_q[1] & ~ext_q[2];
        ext_fall = ~ext_q[1] & ext_q[2];
        case (clk_sel)
            3'd1:    tick = 1'b1;
            3'd2:    tick = &pre_q[T8-1:0];
            3'd3:    tick = &pre_q[T64-1:0];
            3'd4:    tick = &pre_q[T256-1:0];
            3'd5:    tick = &pre_q[T1K-1:0];
            3'd6:    tick = ext_fall;
            3'd7:    tick = ext_rise;
            default: tick = 1'b0;
        endcase
    end

    // R4: an external rising edge gives one tick, never two in a row
    assert_ext_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd7 && tick) |=> (clk_sel != 3'd7 || !tick));

endmodule

// File: rtl/mtim_capture.sv
`timescale 1ns/1ps
module mtim_capture #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic filt_en,
    input  logic rise_sel,
    output logic evt
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic [1:0]       sync_q;
    logic             acc_q;
    logic             prev_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            acc_q  <= 1'b0;
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_in};
            prev_q <= acc_q;
            if (!filt_en) begin
                acc_q <= sync_q[1];
                run_q <= '0;
            end else if (sync_q[1] != acc_q) begin
                if (run_q == RUN_W'(FILT_LEN - 1)) begin
                    acc_q <= sync_q[1];
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    always_comb begin
        evt = rise_sel ? (acc_q & ~prev_q) : (~acc_q & prev_q);
    end

    // R10: the accepted level only ever moves to the latest synchronised sample
    assert_filter_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q != $past(acc_q)) |-> ($past(sync_q[1]) == acc_q));

endmodule

// File: rtl/mtim_core.sv
`timescale 1ns/1ps
module mtim_core
    import mtim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] top,
    input  shape_e           shape,
    output logic [CNT_W-1:0] cnt_q,
    output logic             going_up,
    output logic             bottom_evt
);
    typedef enum logic {ST_UP, ST_DOWN} dir_e;

    dir_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             dual, at_top, at_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        dual    = (shape == SHP_DUAL);
        at_top  = (cnt_q == top);
        at_zero = (cnt_q == '0);
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                ST_UP: begin
                    if (at_top && dual) begin
                        state_d = ST_DOWN;
                        cnt_d   = cnt_q - 1'b1;
                    end else if (at_top) begin
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (at_zero) begin
                        state_d = ST_UP;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
        if (!dual || restart) state_d = ST_UP;
        if (ld_en) cnt_d = ld_val;
    end

    always_comb begin
        going_up   = (state_q == ST_UP);
        bottom_evt = tick && (((state_q == ST_UP) && !dual && at_top) ||
                              ((state_q == ST_DOWN) && at_zero));
    end

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_en) |=> $stable(cnt_q));

    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !dual && cnt_q == top) |=> (cnt_q == '0));

    assert_turn_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && dual && state_q == ST_DOWN && cnt_q == '0)
        |=> (state_q == ST_UP && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/mtim_chan.sv
`timescale 1ns/1ps
module mtim_chan
    import mtim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             force_i,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  shape_e           shape,
    input  act_e             act,
    input  logic             going_up,
    input  logic             bottom_evt,
    output logic             pin_q,
    output logic             match
);
    logic pin_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    always_comb begin
        match = tick && (cnt == cmp);
        pin_d = pin_q;
        unique case (shape)
            SHP_NORMAL: begin
                if (match || force_i) begin
                    case (act)
                        ACT_TOGGLE: pin_d = ~pin_q;
                        ACT_CLEAR:  pin_d = 1'b0;
                        ACT_SET:    pin_d = 1'b1;
                        default:    pin_d = pin_q;
                    endcase
                end
            end
            SHP_SINGLE: begin
                if (bottom_evt && act[1])  pin_d = ~act[0];
                else if (match && act[1])  pin_d = act[0];
            end
            SHP_DUAL: begin
                if (match && act[1]) pin_d = going_up ? act[0] : ~act[0];
            end
            default: pin_d = pin_q;
        endcase
    end

    assert_pin_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shape == SHP_NORMAL && !match && !force_i) |=> $stable(pin_q));

    assert_dual_up_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shape == SHP_DUAL && match && act == ACT_CLEAR && going_up) |=> !pin_q);

endmodule

// File: rtl/mtimer16.sv
`timescale 1ns/1ps
module mtimer16
    import mtim_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int N_CH     = 3,
    parameter int FILT_LEN = 4,
    parameter int PRE_W    = 10,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    output logic [N_CH-1:0]   cmp_pin,
    output logic [N_CH+1:0]   flags,
    output logic              irq
);
    localparam int CTRL_W = F_ACT + 2 * N_CH;
    localparam int FLG_W  = N_CH + 2;
    localparam int F_CAPF = N_CH + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cmp_buf [N_CH];
    logic [CNT_W-1:0]  cmp_eff [N_CH];
    logic [CNT_W-1:0]  cmpa_act, cap_q, top_val, cnt;
    logic [FLG_W-1:0]  ien_q, flg_q, flg_set, flg_clr;
    logic [N_CH-1:0]   force_v, match_v;
    mode_t             mi;
    logic              tick, cap_evt, going_up, bottom_evt;
    logic              ctrl_wr, cnt_wr, cap_wr, cmpa_wr, flg_wr;

    always_comb begin
        mi      = decode_mode(ctrl_q[F_MODE +: 4]);
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        cnt_wr  = wr_en && (wr_addr == ADDR_W'(A_COUNT));
        cap_wr  = wr_en && (wr_addr == ADDR_W'(A_CAPT));
        cmpa_wr = wr_en && (wr_addr == ADDR_W'(A_CMP0));
        flg_wr  = wr_en && (wr_addr == ADDR_W'(A_FLAGS));
        force_v = (wr_en && wr_addr == ADDR_W'(A_FORCE)) ? wr_data[N_CH-1:0] : '0;
        flg_clr = flg_wr ? wr_data[FLG_W-1:0] : '0;
        flg_set = {cap_evt && !mi.cap_is_top, match_v, bottom_evt};
        case (mi.top)
            TOP_CMPA:   top_val = cmpa_act;
            TOP_CAPT:   top_val = cap_q;
            TOP_BITS8:  top_val = CNT_W'(255);
            TOP_BITS9:  top_val = CNT_W'(511);
            TOP_BITS10: top_val = CNT_W'(1023);
            default:    top_val = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cap_q    <= '0;
            ien_q    <= '0;
            flg_q    <= '0;
            cmpa_act <= '0;
            for (int i = 0; i < N_CH; i++) cmp_buf[i] <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_IEN)) ien_q <= wr_data[FLG_W-1:0];
            for (int i = 0; i < N_CH; i++)
                if (wr_en && wr_addr == ADDR_W'(A_CMP0 + i)) cmp_buf[i] <= wr_data;
            if (cap_wr)                            cap_q <= wr_data;
            else if (cap_evt && !mi.cap_is_top)    cap_q <= cnt;
            if (!mi.buffered)  cmpa_act <= cmpa_wr ? wr_data : cmp_buf[0];
            else if (bottom_evt) cmpa_act <= cmp_buf[0];
            flg_q <= (flg_q & ~flg_clr) | flg_set;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL):  rd_data = CNT_W'(ctrl_q);
            ADDR_W'(A_COUNT): rd_data = cnt;
            ADDR_W'(A_CAPT):  rd_data = cap_q;
            ADDR_W'(A_IEN):   rd_data = CNT_W'(ien_q);
            ADDR_W'(A_FLAGS): rd_data = CNT_W'(flg_q);
            default: begin
                for (int i = 0; i < N_CH; i++)
                    if (rd_addr == ADDR_W'(A_CMP0 + i)) rd_data = cmp_buf[i];
            end
        endcase
        flags = flg_q;
        irq   = |(flg_q & ien_q);
    end

    mtim_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clk_sel(ctrl_q[F_CLK +: 3]),
        .ext_in(ext_clk_in), .tick(tick)
    );

    mtim_capture #(.FILT_LEN(FILT_LEN)) u_capt (
        .clk(clk), .rst_n(rst_n), .pin_in(cap_in), .filt_en(ctrl_q[F_FILT]),
        .rise_sel(ctrl_q[F_EDGE]), .evt(cap_evt)
    );

    mtim_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ctrl_wr),
        .ld_en(cnt_wr), .ld_val(wr_data), .top(top_val), .shape(mi.shape),
        .cnt_q(cnt), .going_up(going_up), .bottom_evt(bottom_evt)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        if (g == 0) begin : g_a
            assign cmp_eff[g] = cmpa_act;
        end else begin : g_o
            assign cmp_eff[g] = cmp_buf[g];
        end
        mtim_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick), .force_i(force_v[g]),
            .cnt(cnt), .cmp(cmp_eff[g]), .shape(mi.shape),
            .act(act_e'(ctrl_q[F_ACT + 2*g +: 2])), .going_up(going_up),
            .bottom_evt(bottom_evt), .pin_q(cmp_pin[g]), .match(match_v[g])
        );
    end

    assert_ovf_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_evt |=> flg_q[0]);

    assert_capt_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mi.cap_is_top && !cap_wr) |=> $stable(cap_q));

    assert_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_wr && wr_data[F_CAPF] && !(cap_evt && !mi.cap_is_top)) |=> !flg_q[F_CAPF]);

endmodule

// File: tb/mtimer16_tb.sv
`timescale 1ns/1ps
module mtimer16_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    logic        ext_clk_in = 1'b0, cap_in = 1'b0;
    logic [2:0]  cmp_pin;
    logic [4:0]  flags;
    logic        irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mtimer16 u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk_in(ext_clk_in), .cap_in(cap_in),
        .cmp_pin(cmp_pin), .flags(flags), .irq(irq)
    );

    // model state
    int   m_mode, m_cnt, m_cmpa, m_cmpa_buf, m_cmpb, m_cmpc, m_cap;
    bit   m_up;
    bit [2:0] m_pin;
    bit [4:0] m_flg;
    int   m_act [3];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        rd_addr = 4'(a);
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_rise();
        ext_clk_in = 1'b1; idle(4);
        ext_clk_in = 1'b0; idle(4);
    endtask

    task automatic pulse_cap(input int n);
        cap_in = 1'b1; idle(n);
        cap_in = 1'b0; idle(10);
    endtask

    function automatic int mk_ctrl(int mode, int ck, int edg, int filt, int aa, int ab, int ac);
        return mode | (ck << 4) | (edg << 7) | (filt << 8) | (aa << 9) | (ab << 11) | (ac << 13);
    endfunction

    function automatic int shp(int mode);
        if (mode == 5 || mode == 6 || mode == 7 || mode == 14 || mode == 15) return 1;
        if (mode == 8 || mode == 9) return 2;
        return 0;
    endfunction

    function automatic int m_top();
        case (m_mode)
            4, 9, 15:  return m_cmpa;
            8, 12, 14: return m_cap;
            5: return 255;
            6: return 511;
            7: return 1023;
            default: return 65535;
        endcase
    endfunction

    task automatic model_tick();
        int  top, nxt, sh, cmpv;
        bit  bottom, up_next, match;
        top = m_top(); sh = shp(m_mode); up_next = m_up; bottom = 0;
        if (m_up) begin
            if (m_cnt == top) begin
                if (sh == 2) begin up_next = 0; nxt = m_cnt - 1; end
                else begin nxt = 0; bottom = 1; end
            end else nxt = (m_cnt + 1) & 16'hFFFF;
        end else begin
            if (m_cnt == 0) begin up_next = 1; nxt = 1; bottom = 1; end
            else nxt = m_cnt - 1;
        end
        for (int i = 0; i < 3; i++) begin
            cmpv  = (i == 0) ? m_cmpa : ((i == 1) ? m_cmpb : m_cmpc);
            match = (m_cnt == cmpv);
            if (match) m_flg[1+i] = 1'b1;
            if (sh == 0) begin
                if (match) case (m_act[i])
                    1: m_pin[i] = ~m_pin[i];
                    2: m_pin[i] = 1'b0;
                    3: m_pin[i] = 1'b1;
                    default: ;
                endcase
            end else if (sh == 1) begin
                if (bottom && m_act[i] >= 2)      m_pin[i] = (m_act[i] == 2);
                else if (match && m_act[i] >= 2)  m_pin[i] = (m_act[i] == 3);
            end else begin
                if (match && m_act[i] >= 2) m_pin[i] = m_up ? (m_act[i] == 3) : (m_act[i] == 2);
            end
        end
        if (bottom) m_flg[0] = 1'b1;
        if (m_mode == 15 && bottom) m_cmpa = m_cmpa_buf;
        m_cnt = nxt; m_up = up_next;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, c0, c1;
        int modes [9] = '{4, 5, 6, 7, 8, 9, 12, 14, 15};
        int t, steps, nv, pa;
        string tg;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R13 reset state
        rd(1, d); chk("R13 reset count", d, 0);
        chk("R13 reset flags", flags, 0);
        chk("R13 reset pins", cmp_pin, 0);
        chk("R13 reset irq", irq, 0);
        wr(7, 16'hBEEF); rd(7, d); chk("R13 compare B readback", d, 16'hBEEF);
        rd(5, d); chk("R13 force reads zero", d, 0);

        // R1 full-range wrap
        wr(0, mk_ctrl(0, 7, 1, 0, 0, 0, 0));
        wr(1, 16'hFFFE);
        step_rise(); rd(1, d); chk("R1 count at FFFF", d, 16'hFFFF);
        chk("R1 no overflow yet", flags[0], 0);
        step_rise(); rd(1, d); chk("R1 wrap to zero", d, 0);
        chk("R1 overflow flag", flags[0], 1);

        // R12 enables, irq and write-one-to-clear
        wr(3, 1); chk("R12 irq with enable", irq, 1);
        wr(3, 0); chk("R12 irq without enable", irq, 0);
        wr(4, 16'h1F); chk("R12 flags cleared", flags, 0);

        // R4 prescaler selections
        wr(0, mk_ctrl(0, 1, 1, 0, 0, 0, 0));
        rd(1, c0); idle(10); rd(1, c1); chk("R4 divide by 1", 16'(c1 - c0), 10);
        wr(0, mk_ctrl(0, 2, 1, 0, 0, 0, 0));
        rd(1, c0); idle(64); rd(1, c1); chk("R4 divide by 8", 16'(c1 - c0), 8);
        wr(0, mk_ctrl(0, 3, 1, 0, 0, 0, 0));
        rd(1, c0); idle(256); rd(1, c1); chk("R4 divide by 64", 16'(c1 - c0), 4);
        wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
        rd(1, c0); idle(50); rd(1, c1); chk("R4 stopped", 16'(c1 - c0), 0);
        wr(0, mk_ctrl(0, 6, 1, 0, 0, 0, 0));
        rd(1, c0); ext_clk_in = 1'b1; idle(8); rd(1, c1);
        chk("R4 falling select ignores rise", 16'(c1 - c0), 0);
        ext_clk_in = 1'b0; idle(8); rd(1, c1);
        chk("R4 falling select counts fall", 16'(c1 - c0), 1);

        // R11 force compare
        wr(0, mk_ctrl(0, 0, 1, 0, 1, 3, 0));
        wr(4, 16'h1F);
        pa = cmp_pin[0];
        wr(5, 3);
        chk("R11 force toggles A", cmp_pin[0], !pa);
        chk("R11 force sets B", cmp_pin[1], 1);
        chk("R11 force sets no flag", flags, 0);
        wr(0, mk_ctrl(5, 0, 1, 0, 2, 0, 0));
        pa = cmp_pin[0];
        wr(5, 1);
        chk("R11 force ignored in PWM mode", cmp_pin[0], pa);

        // R9 capture edges
        wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
        wr(4, 16'h1F); wr(1, 16'h1234);
        cap_in = 1'b1; idle(8);
        rd(2, d); chk("R9 rising capture value", d, 16'h1234);
        chk("R9 rising capture flag", flags[4], 1);
        cap_in = 1'b0; idle(8);
        wr(0, mk_ctrl(0, 0, 0, 0, 0, 0, 0));
        wr(4, 16'h1F); wr(1, 16'h0055);
        cap_in = 1'b1; idle(8);
        chk("R9 falling select ignores rise", flags[4], 0);
        wr(1, 16'h0066);
        cap_in = 1'b0; idle(8);
        rd(2, d); chk("R9 falling capture value", d, 16'h0066);
        chk("R9 falling capture flag", flags[4], 1);
        wr(0, mk_ctrl(12, 0, 1, 0, 0, 0, 0));
        wr(4, 16'h1F); wr(2, 16'h0777); wr(1, 16'h0099);
        pulse_cap(6);
        rd(2, d); chk("R9 capture inhibited when top", d, 16'h0777);
        chk("R9 no capture flag when top", flags[4], 0);

        // R10 noise filter boundary
        wr(0, mk_ctrl(0, 0, 1, 1, 0, 0, 0));
        wr(4, 16'h1F); wr(1, 16'h0021); wr(2, 0);
        pulse_cap(3);
        chk("R10 three-sample pulse dropped", flags[4], 0);
        pulse_cap(4);
        chk("R10 four-sample pulse kept", flags[4], 1);
        rd(2, d); chk("R10 filtered capture value", d, 16'h0021);
        wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
        wr(4, 16'h1F);
        pulse_cap(2);
        chk("R10 unfiltered short pulse kept", flags[4], 1);

        // R8 directed buffered load
        wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
        wr(6, 5); wr(1, 0);
        wr(0, mk_ctrl(15, 7, 1, 0, 0, 0, 0));
        wr(6, 9);
        rd(6, d); chk("R8 read returns holding value", d, 9);
        repeat (5) step_rise();
        rd(1, d); chk("R8 old top still active", d, 5);
        step_rise(); rd(1, d); chk("R8 wrap on old top", d, 0);
        repeat (9) step_rise();
        rd(1, d); chk("R8 new top reached", d, 9);
        step_rise(); rd(1, d); chk("R8 wrap on new top", d, 0);

        // random runs over every counting mode, stepped one tick at a time
        foreach (modes[k]) begin
            m_mode = modes[k];
            wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
            wr(4, 16'h1F);
            case (m_mode)
                5: t = 255;
                6: t = 511;
                7: t = 1023;
                default: t = 3 + $urandom % 38;
            endcase
            m_cmpa = (m_mode == 4 || m_mode == 9 || m_mode == 15) ? t : $urandom % (t + 1);
            m_cap  = (m_mode == 8 || m_mode == 12 || m_mode == 14) ? t : $urandom % (t + 1);
            m_cmpb = $urandom % (t + 1);
            m_cmpc = $urandom % (t + 1);
            m_cmpa_buf = m_cmpa;
            for (int i = 0; i < 3; i++) m_act[i] = $urandom % 4;
            wr(6, m_cmpa); wr(7, m_cmpb); wr(8, m_cmpc); wr(2, m_cap); wr(1, 0);
            m_pin = cmp_pin; m_flg = '0; m_cnt = 0; m_up = 1;
            wr(0, mk_ctrl(m_mode, 7, 1, 0, m_act[0], m_act[1], m_act[2]));
            steps = 2 * t + 7;
            for (int s = 0; s < steps; s++) begin
                if (m_mode == 15 && s == steps / 2) begin
                    nv = 3 + $urandom % 38;
                    wr(6, nv); m_cmpa_buf = nv;
                end
                step_rise();
                model_tick();
                tg = (m_mode == 15) ? "R8" : ((shp(m_mode) == 2) ? "R3" : "R2");
                rd(1, d); chk($sformatf("%s count mode %0d", tg, m_mode), d, 32'(m_cnt));
                tg = (shp(m_mode) == 0) ? "R5" : ((shp(m_mode) == 1) ? "R6" : "R7");
                chk($sformatf("%s pins mode %0d", tg, m_mode), cmp_pin, 32'(m_pin));
                chk($sformatf("R12 flags mode %0d", m_mode), flags, 32'(m_flg));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule